// File: doc/BRIEF.md
# Frame Status Queue for a Bit-Oriented Receiver

This block keeps one status record per received frame for a bit-oriented receiver of the HDLC family. An upstream deframer supplies decoded strobes: a flag strobe when a flag pattern is seen, a byte strobe for each assembled data byte, and an end-of-frame strobe together with a small status word, such as CRC error and overrun. A byte counter measures each frame. When a frame closes, its length and status are written together as one entry into a small queue. A processor or DMA engine reads the queue later, so a run of short frames can finish before their status is collected.

The read side is a valid/ready stream. `rd_valid` is high whenever at least one entry is stored. The head entry is shown combinationally on `rd_count` and `rd_status`. An entry is removed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_valid` is high and `rd_ready` is low, the head entry holds still. Raising `rd_ready` on an empty queue does nothing. The write side has no back-pressure, because a frame cannot be stalled. A frame that closes while the queue is full is dropped, and a sticky overflow flag records the loss. Software clears the flag and empties the queue by switching `enable` off and then on again.

Top module: `frame_status_fifo`

## Requirements
- R1: With `enable` high, every `byte_stb` adds one to the frame byte counter. This includes a byte strobe in the same cycle as `eof_stb`. The counter stops at 2^CNT_W-1 (16383 by default) and does not wrap.
- R2: A `flag_stb` without `eof_stb` writes no entry. It restarts the byte counter at zero, so bytes seen before an opening flag are not counted in the next frame.
- R3: `eof_stb` with `enable` high writes one entry holding `status_in` and the byte count of the frame. After the write, the counter restarts at zero, including when `flag_stb` is high in the same cycle. Entry count `level` rises by one on the next edge unless the queue is full or a pop also happens in that cycle.
- R4: Entries leave in the order they were written. `rd_count` and `rd_status` show the oldest entry. `rd_valid` is high exactly when `level` is not zero. A pop happens on an edge where `rd_valid` and `rd_ready` are both high.
- R5: `rd_ready` on an empty queue does not move the read side. After such attempts, `level` stays 0, and the next entry written is the one that appears at the head.
- R6: An end of frame that arrives while `level` equals DEPTH is dropped, even if a pop happens in the same cycle, and `overflow` goes high. `overflow` stays high through reads until `enable` is taken low.
- R7: While `enable` is low, `overflow`, `level`, both queue pointers and the byte counter are held at zero, and strobes are ignored. The queue is empty after `enable` returns high.
- R8: A synchronous active-high `rst` clears the queue, the counter and `overflow`.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_count` and `rd_status` stay stable.
- R10: `level` reports the number of stored entries and never exceeds DEPTH (10 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Queue enable; a low level clears the queue, the counter and `overflow` |
| flag_stb | input | 1 | Flag pattern seen |
| byte_stb | input | 1 | One received byte |
| eof_stb | input | 1 | Frame closed; write the entry |
| status_in | input | STAT_W (2) | Frame status captured with `eof_stb` |
| rd_valid | output | 1 | Head entry present |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_count | output | CNT_W (14) | Byte count of the head entry |
| rd_status | output | STAT_W (2) | Status of the head entry |
| level | output | $clog2(DEPTH+1) (4) | Number of stored entries |
| overflow | output | 1 | Sticky: a frame was dropped because the queue was full |

## Verification
The main function is tried with four kinds of frame:
- Frames of several lengths, with the last byte arriving on the end-of-frame cycle. These catch an off-by-one in the counter.
- An empty frame. This shows the counter restarts after every entry.
- Bytes seen before an opening flag. These show that the flag discards them.
- A closing strobe that coincides with the next opening flag. This shows a single entry is written for that boundary.

A fill of DEPTH+2 frames with no reads separates correct drop-on-full behaviour from overwriting, because the drained entries must be exactly the first DEPTH frames.

Three further patterns each isolate one mechanism:
- Reads on an empty queue, followed by one write, reveal any pointer that moved when it should not have.
- Toggling `enable` shows that it is the only way to clear the overflow flag.
- A run longer than the counter range shows that the count saturates rather than wraps.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  localparam int FSF_DEPTH  = 10;
  localparam int FSF_CNT_W  = 14;
  localparam int FSF_STAT_W = 2;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_BUMP  = 2'd1,
    CNT_CLEAR = 2'd2
  } cnt_action_e;
endpackage

// File: rtl/fsf_byte_counter.sv
module fsf_byte_counter
  import fsf_pkg::*;
#(
  parameter int CNT_W = FSF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             flag_stb,
  input  logic             byte_stb,
  input  logic             eof_stb,
  output logic [CNT_W-1:0] frame_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bumped;
  cnt_action_e      action;

  // a byte on the closing cycle belongs to the closing frame
  always_comb begin
    if (byte_stb && (cnt_q != CNT_MAX)) bumped = cnt_q + CNT_W'(1);
    else                                bumped = cnt_q;
  end

  assign frame_len = bumped;

  always_comb begin
    if (!enable)                 action = CNT_CLEAR;
    else if (flag_stb || eof_stb) action = CNT_CLEAR;
    else if (byte_stb)           action = CNT_BUMP;
    else                         action = CNT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (action)
        CNT_CLEAR: cnt_q <= '0;
        CNT_BUMP:  cnt_q <= bumped;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fsf_ptr_ctrl.sv
module fsf_ptr_ctrl
  import fsf_pkg::*;
#(
  parameter int DEPTH = FSF_DEPTH,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          overflow
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic full;

  assign empty   = (level == '0);
  assign full    = (level == FULL);
  // a full queue drops the frame even if a pop happens this cycle
  assign push_ok = enable && push_req && !full;
  assign pop_ok  = enable && pop_req && !empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= wrap_inc(wptr);
      if (pop_ok)  rptr <= wrap_inc(rptr);
      unique case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (push_req && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/fsf_store.sv
module fsf_store
  import fsf_pkg::*;
#(
  parameter int DEPTH = FSF_DEPTH,
  parameter int W     = FSF_CNT_W + FSF_STAT_W,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) slot[g] <= wdata;
    end
  end

  always_comb begin
    rdata = slot[0];
    for (int k = 0; k < DEPTH; k++) begin
      if (raddr == AW'(k)) rdata = slot[k];
    end
  end
endmodule

// File: rtl/frame_status_fifo.sv
module frame_status_fifo
  import fsf_pkg::*;
#(
  parameter int DEPTH  = FSF_DEPTH,
  parameter int CNT_W  = FSF_CNT_W,
  parameter int STAT_W = FSF_STAT_W,
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              flag_stb,
  input  logic              byte_stb,
  input  logic              eof_stb,
  input  logic [STAT_W-1:0] status_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CNT_W-1:0]  rd_count,
  output logic [STAT_W-1:0] rd_status,
  output logic [LW-1:0]     level,
  output logic              overflow
);
  localparam int AW      = $clog2(DEPTH);
  localparam int ENTRY_W = STAT_W + CNT_W;

  logic [CNT_W-1:0]   frame_len;
  logic               push_ok;
  logic               pop_ok;
  logic [AW-1:0]      wptr;
  logic [AW-1:0]      rptr;
  logic               empty;
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] head;

  fsf_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .flag_stb (flag_stb),
    .byte_stb (byte_stb),
    .eof_stb  (eof_stb),
    .frame_len(frame_len)
  );

  fsf_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .push_req(eof_stb),
    .pop_req (rd_ready),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wptr    (wptr),
    .rptr    (rptr),
    .level   (level),
    .empty   (empty),
    .overflow(overflow)
  );

  assign wr_entry = {status_in, frame_len};

  fsf_store #(.DEPTH(DEPTH), .W(ENTRY_W), .AW(AW)) u_store (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wptr),
    .wdata(wr_entry),
    .raddr(rptr),
    .rdata(head)
  );

  assign rd_valid  = !empty;
  assign rd_count  = head[CNT_W-1:0];
  assign rd_status = head[ENTRY_W-1:CNT_W];
endmodule

// File: rtl/fsf_chk.sv
module fsf_chk #(
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 14,
  parameter int STAT_W = 2,
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              eof_stb,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  rd_count,
  input logic [STAT_W-1:0] rd_status,
  input logic [LW-1:0]     level,
  input logic              overflow
);
  // R3
  push_level_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && eof_stb && level < LW'(DEPTH) && !rd_ready) |=> (level == LW'($past(level) + LW'(1))));

  // R4
  valid_level_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (level != '0));

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !rd_valid && rd_ready && !eof_stb) |=> (level == '0));

  // R6
  overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && eof_stb && level == LW'(DEPTH)) |=> overflow);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && overflow) |=> overflow);

  // R7
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (level == '0 && !overflow && !rd_valid));

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_count) && $stable(rd_status)));

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
endmodule

bind frame_status_fifo fsf_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .STAT_W(STAT_W), .LW(LW)
) u_fsf_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .eof_stb  (eof_stb),
  .rd_ready (rd_ready),
  .rd_valid (rd_valid),
  .rd_count (rd_count),
  .rd_status(rd_status),
  .level    (level),
  .overflow (overflow)
);

// File: tb/frame_status_fifo_test.sv
`timescale 1ns/1ps
module frame_status_fifo_test;
  localparam int DEPTH   = 10;
  localparam int CNT_W   = 14;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, enable = 1'b0;
  logic        flag_stb = 1'b0, byte_stb = 1'b0, eof_stb = 1'b0;
  logic [1:0]  status_in = '0;
  logic        rd_valid, rd_ready;
  logic [13:0] rd_count;
  logic [1:0]  rd_status;
  logic [3:0]  level;
  logic        overflow;
  logic        mon_ready = 1'b0, tb_ready = 1'b0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  assign rd_ready = mon_ready | tb_ready;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];

  frame_status_fifo uut (
    .clk(clk), .rst(rst), .enable(enable), .flag_stb(flag_stb),
    .byte_stb(byte_stb), .eof_stb(eof_stb), .status_in(status_in),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_count(rd_count),
    .rd_status(rd_status), .level(level), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: opening flag, bytes (last one on the closing cycle), closing strobe
  task automatic send_frame(input int nbytes, input logic [1:0] st, input bit expect_push);
    int len;
    @(negedge clk);
    flag_stb = 1'b1;
    @(negedge clk);
    flag_stb = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      byte_stb = 1'b1;
      if (i == nbytes - 1) begin eof_stb = 1'b1; status_in = st; end
      @(negedge clk);
    end
    if (nbytes == 0) begin
      eof_stb = 1'b1; status_in = st;
      @(negedge clk);
    end
    byte_stb = 1'b0;
    eof_stb  = 1'b0;
    len = (nbytes > CNT_MAX) ? CNT_MAX : nbytes;
    if (expect_push) exp_q.push_back({st, 14'(len)});
  endtask

  // monitor: compares the head with the scoreboard, then takes it
  always @(negedge clk) begin
    if (mon_on && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected entry", int'(rd_count), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({rd_status, rd_count} == e, "R3/R4 entry {status,count}",
              int'({rd_status, rd_count}), int'(e));
      end
      mon_ready = 1'b1;
    end else begin
      mon_ready = 1'b0;
    end
  end

  task automatic drain();
    mon_on = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R4 empty after drain", int'(rd_valid), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] held_c;
    idle(3);
    // R8 reset state
    check(rd_valid == 1'b0, "R8 rd_valid", int'(rd_valid), 0);
    check(level == 4'd0, "R8 level", int'(level), 0);
    check(overflow == 1'b0, "R8 overflow", int'(overflow), 0);
    rst = 1'b0;
    enable = 1'b1;
    idle(2);

    // R1 R3 frames of distinct lengths, incl. an empty frame
    send_frame(3, 2'b01, 1'b1);
    send_frame(0, 2'b10, 1'b1);
    send_frame(5, 2'b11, 1'b1);
    // R2 bytes before an opening flag are discarded
    for (int i = 0; i < 4; i++) begin byte_stb = 1'b1; @(negedge clk); end
    byte_stb = 1'b0;
    send_frame(2, 2'b00, 1'b1);
    check(level == 4'd4, "R10 level after four frames", int'(level), 4);
    // R9 head held while not ready
    held_c = rd_count;
    idle(3);
    check(rd_count == held_c && rd_valid, "R9 head stable", int'(rd_count), int'(held_c));
    drain();

    // R3 closing strobe coinciding with the next opening flag
    for (int i = 0; i < 2; i++) begin byte_stb = 1'b1; @(negedge clk); end
    byte_stb = 1'b0;
    flag_stb = 1'b1; eof_stb = 1'b1; status_in = 2'b01;
    @(negedge clk);
    flag_stb = 1'b0; eof_stb = 1'b0;
    exp_q.push_back({2'b01, 14'd2});
    for (int i = 0; i < 3; i++) begin byte_stb = 1'b1; @(negedge clk); end
    byte_stb = 1'b0;
    eof_stb = 1'b1; status_in = 2'b10;
    @(negedge clk);
    eof_stb = 1'b0;
    exp_q.push_back({2'b10, 14'd3});
    check(level == 4'd2, "R3 one entry per boundary", int'(level), 2);
    drain();

    // R5 pops on an empty queue
    tb_ready = 1'b1;
    idle(3);
    tb_ready = 1'b0;
    check(level == 4'd0, "R5 level after empty pops", int'(level), 0);
    send_frame(7, 2'b01, 1'b0);
    idle(1);
    check(level == 4'd1, "R5 level after one write", int'(level), 1);
    check(rd_count == 14'd7, "R5 head is new entry", int'(rd_count), 7);
    tb_ready = 1'b1; @(negedge clk); tb_ready = 1'b0;

    // R6 overflow: DEPTH+2 frames with no reads
    for (int i = 0; i < DEPTH + 2; i++) send_frame(i + 1, 2'(i % 4), i < DEPTH);
    check(level == 4'(DEPTH), "R10 level at full", int'(level), DEPTH);
    check(overflow == 1'b1, "R6 overflow set", int'(overflow), 1);
    drain();
    check(overflow == 1'b1, "R6 overflow sticky through reads", int'(overflow), 1);

    // R7 disable clears and ignores strobes
    enable = 1'b0;
    idle(1);
    check(overflow == 1'b0, "R7 overflow cleared", int'(overflow), 0);
    send_frame(4, 2'b11, 1'b0);
    check(level == 4'd0, "R7 strobes ignored while disabled", int'(level), 0);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) begin byte_stb = 1'b1; @(negedge clk); end
    byte_stb = 1'b0;
    enable = 1'b0; @(negedge clk); enable = 1'b1; @(negedge clk);
    eof_stb = 1'b1; status_in = 2'b10; @(negedge clk); eof_stb = 1'b0;
    exp_q.push_back({2'b10, 14'd0});
    drain();

    // R1 counter saturation
    send_frame(CNT_MAX + 20, 2'b10, 1'b1);
    drain();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule